// File: doc/BRIEF.md
# Timer Channel Polarity and Capture Conditioner

This block conditions a single timer channel that works either as a capture input or as a compare output. The same three configuration bits serve both directions: an enable bit, a polarity bit and a complementary-polarity bit. Their meaning changes with the direction selected by `out_mode`.

In input mode, the already-filtered channel input is passed through a synchronizer. Edges are found by comparing the newest synchronized sample with the one before it. The two-bit code `{cfg_npol, cfg_pol}` chooses which edges raise `edge_pulse`, and whether the `level_out` copy of the input is inverted, as used when the channel gates a trigger. When the enable bit is set, each selected edge copies the free-running counter value into a capture register. A small capture-status state machine keeps a capture flag and an overcapture flag, and a clear strobe resets them.

In output mode, the reference compare waveform is XORed with the polarity bit and gated by the enable bit. The result is registered onto `oc_out`. While the output is disabled it is held at 0, and `pin_released` tells the pad logic to return the pin to default I/O control.

The capture-status state machine has three states:
- `CAP_EMPTY`: no unread capture.
- `CAP_FULL`: one unread capture.
- `CAP_OVER`: a capture arrived while one was still unread.

Its transitions are:
- take: `CAP_EMPTY` to `CAP_FULL`, on a capture.
- overrun: `CAP_FULL` or `CAP_OVER` to `CAP_OVER`, on a capture without a clear.
- drain: `CAP_FULL` or `CAP_OVER` to `CAP_EMPTY`, on a clear without a capture.
- retake: any state to `CAP_FULL`, on a capture and a clear in the same cycle.
- In every other case the state holds.

Top module: `tmr_chan_cond`

## Requirements
- R1: With input mode and code `{cfg_npol,cfg_pol}` = 2'b00, a rising input edge gives a one-cycle `edge_pulse`, a falling edge gives none, and `level_out` equals the synchronized input.
- R2: With code 2'b01, only a falling edge gives a one-cycle `edge_pulse`, and `level_out` is the inverse of the synchronized input.
- R3: With code 2'b11, both edges give a one-cycle `edge_pulse`, and `level_out` is not inverted.
- R4: In input mode, code 2'b10 raises `cfg_err` and no `edge_pulse` is produced for any input edge. `level_out` is not inverted.
- R5: In input mode with `cfg_en`=1, each edge pulse copies `cnt_val` into `cap_val` on the next clock edge and sets `cap_flag`. With `cfg_en`=0, `cap_val` and the flags are left unchanged.
- R6: A capture while `cap_flag` is set raises `ovr_flag`. A `flag_clr` without a capture clears both flags. A capture and a `flag_clr` in the same cycle leave `cap_flag`=1 and `ovr_flag`=0.
- R7: In output mode with `cfg_en`=1, `oc_out` equals `cmp_ref` XOR `cfg_pol` (0 = active high, 1 = active low), one clock after the inputs.
- R8: `cfg_en`=0 in output mode, or input mode, drives `oc_out` to 0 and `pin_released` to 1, one clock later.
- R9: In output mode, `cfg_npol`=1 raises `cfg_err`, and `cfg_npol`=0 clears it.
- R10: An input change reaches `edge_pulse` and `level_out` on the second rising clock edge after it is applied, and the pulse lasts exactly one cycle.
- R11: Reset sets `cap_val` to 0, clears both flags and `edge_pulse`, drives `oc_out` to 0 and sets `pin_released` to 1.
- R12: In output mode, input edges produce no `edge_pulse` and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_mode | input | 1 | 1 = compare output, 0 = capture input |
| cfg_en | input | 1 | Enable bit: capture enable or output enable |
| cfg_pol | input | 1 | Polarity bit |
| cfg_npol | input | 1 | Complementary-polarity bit |
| chan_in | input | 1 | Filtered channel input, asynchronous |
| cnt_val | input | CNT_W | Free-running counter value |
| cmp_ref | input | 1 | Reference compare waveform |
| flag_clr | input | 1 | Strobe that clears the capture flags |
| edge_pulse | output | 1 | One-cycle pulse on each selected edge |
| level_out | output | 1 | Synchronized input level after polarity |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Unread capture present |
| ovr_flag | output | 1 | Capture lost to overcapture |
| cfg_err | output | 1 | Illegal configuration code |
| oc_out | output | 1 | Conditioned compare output |
| pin_released | output | 1 | Output disabled; pin returned to default I/O |

## Verification
All four polarity codes are tried against every pair of old and new input levels. This separates rising, falling, both-edge and reserved sensitivity, and shows whether the level is inverted. Capture is tried as four sequences:
- a single capture;
- a second capture without a clear;
- a plain clear;
- a capture that coincides with a clear.

These tell the take, overrun, drain and retake transitions apart, and a disabled-enable pass shows that capture is suppressed. Output mode is swept over all eight combinations of enable, polarity and reference. Input edges are then toggled in output mode to show that nothing leaks from the input side.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    // {cfg_npol, cfg_pol} in input mode
    typedef enum logic [1:0] {
        POL_RISE = 2'b00,
        POL_FALL = 2'b01,
        POL_RSVD = 2'b10,
        POL_BOTH = 2'b11
    } pol_code_t;

    typedef enum logic [1:0] {
        CAP_EMPTY = 2'b00,
        CAP_FULL  = 2'b01,
        CAP_OVER  = 2'b10
    } cap_state_t;

endpackage

// File: rtl/tcp_edge_det.sv
module tcp_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg[0] <= 1'b0;
        end else begin
            shreg[0] <= din;
        end
    end

    for (genvar i = 1; i < CHAIN; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg[i] <= 1'b0;
            end else begin
                shreg[i] <= shreg[i-1];
            end
        end
    end

    assign lvl  = shreg[SYNC_STAGES-1];
    assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    assign fall = ~shreg[SYNC_STAGES-1] & shreg[SYNC_STAGES];

endmodule

// File: rtl/tcp_capture.sv
module tcp_capture
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);
    cap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: begin
                if (cap_stb)   state_d = CAP_FULL;
            end
            CAP_FULL, CAP_OVER: begin
                if (cap_stb && clr)   state_d = CAP_FULL;
                else if (cap_stb)     state_d = CAP_OVER;
                else if (clr)         state_d = CAP_EMPTY;
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (cap_stb) begin
            cap_val <= cnt_val;
        end
    end

    always_comb begin
        cap_flag = 1'b0;
        ovr_flag = 1'b0;
        unique case (state_q)
            CAP_EMPTY: ;
            CAP_FULL:  cap_flag = 1'b1;
            CAP_OVER: begin
                cap_flag = 1'b1;
                ovr_flag = 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    take_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> cap_flag);

    // R5
    hold_without_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(cap_val));

    // R6
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && cap_stb && !clr) |=> ovr_flag);

    // R6
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cap_stb) |=> (!cap_flag && !ovr_flag));

endmodule

// File: rtl/tcp_out_stage.sv
module tcp_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic en,
    input  logic pol,
    input  logic ref_i,
    output logic oc_out,
    output logic released
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_out   <= 1'b0;
            released <= 1'b1;
        end else if (active && en) begin
            oc_out   <= ref_i ^ pol;
            released <= 1'b0;
        end else begin
            oc_out   <= 1'b0;
            released <= 1'b1;
        end
    end

    // R7
    drive_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && en) |=> (oc_out == $past(ref_i ^ pol)));

    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && en) |=> (!oc_out && released));

endmodule

// File: rtl/tmr_chan_cond.sv
module tmr_chan_cond
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_mode,
    input  logic             cfg_en,
    input  logic             cfg_pol,
    input  logic             cfg_npol,
    input  logic             chan_in,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cmp_ref,
    input  logic             flag_clr,
    output logic             edge_pulse,
    output logic             level_out,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag,
    output logic             cfg_err,
    output logic             oc_out,
    output logic             pin_released
);
    pol_code_t code;
    logic      s_lvl, s_rise, s_fall;
    logic      sel_edge, lvl_inv, cap_stb;

    assign code = pol_code_t'({cfg_npol, cfg_pol});

    tcp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (chan_in),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    always_comb begin
        sel_edge = 1'b0;
        lvl_inv  = 1'b0;
        unique case (code)
            POL_RISE: sel_edge = s_rise;
            POL_FALL: begin
                sel_edge = s_fall;
                lvl_inv  = 1'b1;
            end
            POL_BOTH: sel_edge = s_rise | s_fall;
            POL_RSVD: sel_edge = 1'b0;
            default:  sel_edge = 1'b0;
        endcase
    end

    assign edge_pulse = ~out_mode & sel_edge;
    assign level_out  = s_lvl ^ lvl_inv;
    assign cap_stb    = edge_pulse & cfg_en;
    assign cfg_err    = out_mode ? cfg_npol : (code == POL_RSVD);

    tcp_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_stb (cap_stb),
        .clr     (flag_clr),
        .cnt_val (cnt_val),
        .cap_val (cap_val),
        .cap_flag(cap_flag),
        .ovr_flag(ovr_flag)
    );

    tcp_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (out_mode),
        .en      (cfg_en),
        .pol     (cfg_pol),
        .ref_i   (cmp_ref),
        .oc_out  (oc_out),
        .released(pin_released)
    );

    // R4
    reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_mode && cfg_npol && !cfg_pol) |-> !edge_pulse);

    // R12
    out_mode_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode |-> !edge_pulse);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse && !cfg_npol) |=> !edge_pulse);

endmodule

// File: tb/tmr_chan_cond_tb.sv
module tmr_chan_cond_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          out_mode = 1'b0, cfg_en = 1'b0, cfg_pol = 1'b0, cfg_npol = 1'b0;
    logic          chan_in = 1'b0, cmp_ref = 1'b0, flag_clr = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic          edge_pulse, level_out, cap_flag, ovr_flag, cfg_err, oc_out, pin_released;
    logic [CW-1:0] cap_val;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    tmr_chan_cond #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .cfg_en(cfg_en),
        .cfg_pol(cfg_pol), .cfg_npol(cfg_npol), .chan_in(chan_in),
        .cnt_val(cnt_val), .cmp_ref(cmp_ref), .flag_clr(flag_clr),
        .edge_pulse(edge_pulse), .level_out(level_out), .cap_val(cap_val),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag), .cfg_err(cfg_err),
        .oc_out(oc_out), .pin_released(pin_released)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // input-mode edge trial: settle at 'from', switch to 'to'
    task automatic edge_trial(input logic [1:0] code, input logic from, input logic to);
        logic exp_p, inv;
        cfg_npol = code[1];
        cfg_pol  = code[0];
        chan_in  = from;
        nclk(4);
        chan_in = to;
        nclk(1);
        chk("R10 no pulse before second edge", edge_pulse, 1'b0);
        nclk(1);
        case (code)
            2'b00:   exp_p = to & ~from;
            2'b01:   exp_p = ~to & from;
            2'b11:   exp_p = to ^ from;
            default: exp_p = 1'b0;
        endcase
        inv = (code == 2'b01);
        case (code)
            2'b00: chk("R1 pulse", edge_pulse, exp_p);
            2'b01: chk("R2 pulse", edge_pulse, exp_p);
            2'b11: chk("R3 pulse", edge_pulse, exp_p);
            default: chk("R4 reserved no pulse", edge_pulse, exp_p);
        endcase
        chk("R1 R2 R3 level", level_out, to ^ inv);
        chk("R4 cfg_err input mode", cfg_err, code == 2'b10);
        nclk(1);
        chk("R10 pulse one cycle", edge_pulse, 1'b0);
    endtask

    // produce one rising edge under code 00 and land just after its capture edge
    task automatic rise_capture(input logic [CW-1:0] cv, input logic clr_with);
        chan_in = 1'b0;
        nclk(4);
        cnt_val = cv;
        chan_in = 1'b1;
        nclk(2);
        flag_clr = clr_with;
        nclk(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        nclk(2);
        chk("R11 cap_val", cap_val, '0);
        chk("R11 cap_flag", cap_flag, 1'b0);
        chk("R11 ovr_flag", ovr_flag, 1'b0);
        chk("R11 oc_out", oc_out, 1'b0);
        chk("R11 pin_released", pin_released, 1'b1);
        chk("R11 edge_pulse", edge_pulse, 1'b0);
        rst_n = 1'b1;
        nclk(2);

        // edge sweep with capture disabled
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 2; f++)
                for (int t = 0; t < 2; t++)
                    edge_trial(c[1:0], f[0], t[0]);
        chk("R5 disabled no capture flag", cap_flag, 1'b0);
        chk("R5 disabled cap_val held", cap_val, '0);

        // capture sequences, code 00
        cfg_npol = 1'b0; cfg_pol = 1'b0; cfg_en = 1'b1;
        rise_capture(16'h3A5C, 1'b0);
        chk("R5 take cap_val", cap_val, 16'h3A5C);
        chk("R5 take cap_flag", cap_flag, 1'b1);
        chk("R6 take no ovr", ovr_flag, 1'b0);
        rise_capture(16'h0055, 1'b0);
        chk("R6 overrun cap_val", cap_val, 16'h0055);
        chk("R6 overrun ovr_flag", ovr_flag, 1'b1);
        flag_clr = 1'b1; nclk(1); flag_clr = 1'b0;
        chk("R6 drain cap_flag", cap_flag, 1'b0);
        chk("R6 drain ovr_flag", ovr_flag, 1'b0);
        rise_capture(16'h1111, 1'b0);
        rise_capture(16'h2222, 1'b1);
        chk("R6 retake cap_flag", cap_flag, 1'b1);
        chk("R6 retake ovr_flag", ovr_flag, 1'b0);
        chk("R6 retake cap_val", cap_val, 16'h2222);
        flag_clr = 1'b1; nclk(1); flag_clr = 1'b0;
        cfg_en = 1'b0;
        rise_capture(16'h7777, 1'b0);
        chk("R5 en=0 cap_val held", cap_val, 16'h2222);
        chk("R5 en=0 flag held", cap_flag, 1'b0);

        // output mode sweep
        out_mode = 1'b1;
        for (int v = 0; v < 8; v++) begin
            cfg_en = v[2]; cfg_pol = v[1]; cmp_ref = v[0]; cfg_npol = 1'b0;
            nclk(1);
            if (v[2]) chk("R7 oc_out", oc_out, v[0] ^ v[1]);
            else      chk("R8 oc_out disabled", oc_out, 1'b0);
            chk("R8 pin_released", pin_released, !v[2]);
            chk("R9 cfg_err npol=0", cfg_err, 1'b0);
        end
        cfg_npol = 1'b1;
        nclk(1);
        chk("R9 cfg_err npol=1", cfg_err, 1'b1);
        cfg_npol = 1'b0; cfg_en = 1'b1; cfg_pol = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chan_in = k[0] ? 1'b0 : 1'b1;
            cnt_val = 16'h4000 + CW'(k);
            nclk(2);
            chk("R12 no pulse output mode", edge_pulse, 1'b0);
            nclk(1);
            chk("R12 no capture output mode", cap_flag, 1'b0);
        end
        chk("R12 cap_val held", cap_val, 16'h2222);
        out_mode = 1'b0;
        nclk(1);
        chk("R8 input mode releases pin", pin_released, 1'b1);
        chk("R8 input mode oc_out", oc_out, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule